// File: doc/BRIEF.md
# Dual-Pair Lockstep Supervisor with Checkpoint Failover

The supervisor watches two redundant pairs of processing elements. The primary pair runs first and the backup pair is held as a spare. In every cycle it compares the result words and valid strobes within each pair. While the active pair agrees, it forwards that pair's result. When the two copies in the active pair disagree, it withholds the result for that cycle.

A disagreement inside the primary pair stops the primary. The supervisor then spends one cycle in a failover state, during which it pulses a restart command. After that it hands the output to the backup pair, which resumes from the newest committed checkpoint. Each element also reports its own error flag. When the primary fails, these flags decide which copy is trusted to restore the other.

While the primary is active, a cycle counter emits a one-cycle checkpoint strobe at each interval boundary and advances the checkpoint slot address. Conditions that leave no trustworthy copy lock the block into a fatal state until reset.

Top module: `lockstep_spare_ctrl`

## Requirements
- R1: After synchronous reset the block is in primary mode: out_vld, restart, fatal, ckpt_strobe, ckpt_valid, pri_mismatch, bak_mismatch and trust_sel are 0, ckpt_addr is 0, pri_stall is 0 and bak_stall is 1.
- R2: A pair's mismatch output rises one cycle after a cycle in which its two valid strobes differ, or in which both are high and the data words differ. Two low strobes are not a mismatch.
- R3: One cycle after the active pair shows both valid strobes high and equal data, out_vld is 1 and out_data carries element 0's word. In a mismatching cycle out_vld is 0 on the next cycle.
- R4: A primary mismatch moves the block to failover for exactly one cycle. In that cycle restart is 1, out_vld is 0, pri_stall is 1 and bak_stall is 0. From the following cycle the backup pair's agreeing results are forwarded, and primary inputs have no further effect.
- R5: On a primary mismatch, trust_sel records which copy restores the other: 1 (element 1 trusted) when only element 0 flags a self-error, and 0 otherwise.
- R6: In primary mode, ckpt_strobe pulses for one cycle after every CKPT_PERIOD cycles. Each pulse increments ckpt_addr modulo 2^ADDR_W and sets ckpt_valid.
- R7: If an interval boundary coincides with a primary mismatch, no strobe is issued and ckpt_addr keeps the previous slot. The interval counter stops outside primary mode.
- R8: In primary mode, a cycle where both pairs mismatch, or where both elements of either pair flag self-error, sets fatal. Fatal holds until reset, with out_vld and restart at 0 and both stall outputs at 1.
- R9: In backup mode, a backup mismatch or a double self-error in the backup pair sets fatal.
- R10: A backup mismatch while the primary is active raises only bak_mismatch: forwarding, restart and fatal are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_data | input | 2*DATA_W | Primary results, element 0 in the low half |
| pri_vld | input | 2 | Primary valid strobes, bit = element |
| pri_err | input | 2 | Primary self-error flags, bit = element |
| bak_data | input | 2*DATA_W | Backup results, element 0 in the low half |
| bak_vld | input | 2 | Backup valid strobes |
| bak_err | input | 2 | Backup self-error flags |
| out_data | output | DATA_W | Forwarded result |
| out_vld | output | 1 | Forwarded result valid |
| pri_stall | output | 1 | Primary halted |
| bak_stall | output | 1 | Backup held |
| restart | output | 1 | One-cycle restart command to the backup |
| ckpt_strobe | output | 1 | Checkpoint capture pulse |
| ckpt_addr | output | ADDR_W | Slot of the newest committed checkpoint |
| ckpt_valid | output | 1 | At least one checkpoint committed |
| pri_mismatch | output | 1 | Primary pair disagreed last cycle |
| bak_mismatch | output | 1 | Backup pair disagreed last cycle |
| trust_sel | output | 1 | Copy chosen to restore the other |
| fatal | output | 1 | Sticky unrecoverable fault |

## Verification
The bench aims at the cycle where a checkpoint boundary meets a primary disagreement. A design that commits there would report a slot whose contents came from a faulty interval, and the restart would resume from corrupted state. It also checks that skewed valid strobes with equal data are caught; a comparator that looks only at data would let a lone valid word through. Further cases are a restart pulse that lasts longer than one cycle, a fatal state that clears when good inputs return, and a stray backup disagreement that wrongly triggers failover during primary operation.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
  typedef enum logic [1:0] {
    LS_PRIMARY  = 2'd0,
    LS_FAILOVER = 2'd1,
    LS_BACKUP   = 2'd2,
    LS_FATAL    = 2'd3
  } ls_state_e;
endpackage

// File: rtl/ls_pair_cmp.sv
module ls_pair_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [2*DATA_W-1:0] data,
  input  logic [1:0]          vld,
  input  logic [1:0]          err,
  output logic                mismatch,
  output logic                agree,
  output logic                both_err,
  output logic                trust_b
);
  logic words_differ;

  assign words_differ = data[DATA_W-1:0] != data[2*DATA_W-1:DATA_W];
  // strobe skew counts as a disagreement, as do differing words
  assign mismatch = (vld[0] ^ vld[1]) | (vld[0] & vld[1] & words_differ);
  assign agree    = vld[0] & vld[1] & ~words_differ;
  assign both_err = err[0] & err[1];
  // element 1 restores element 0 only when element 0 alone reports trouble
  assign trust_b  = err[0] & ~err[1];
endmodule

// File: rtl/ls_ckpt_timer.sv
module ls_ckpt_timer #(
  parameter int CKPT_PERIOD = 8,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              block,
  output logic              strobe,
  output logic [ADDR_W-1:0] addr,
  output logic              valid
);
  localparam int CNT_W = (CKPT_PERIOD > 2) ? $clog2(CKPT_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CKPT_PERIOD - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              strobe_q;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic              boundary;

  assign boundary = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      addr_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (run) begin
        cnt_q <= boundary ? '0 : cnt_q + 1'b1;
      end
      if (boundary && !block) begin
        strobe_q <= 1'b1;
        addr_q   <= addr_q + 1'b1;
        valid_q  <= 1'b1;
      end
    end
  end

  assign strobe = strobe_q;
  assign addr   = addr_q;
  assign valid  = valid_q;

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> (addr_q == ADDR_W'($past(addr_q) + 1'b1))); // R6
  AST_HALT_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(addr_q)); // R7
endmodule

// File: rtl/ls_failover_fsm.sv
module ls_failover_fsm
  import lockstep_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pri_mm,
  input  logic      bak_mm,
  input  logic      pri_dbl,
  input  logic      bak_dbl,
  output ls_state_e state,
  output logic      fatal_now,
  output logic      restart,
  output logic      fatal
);
  ls_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    fatal_now = 1'b0;
    case (state_q)
      LS_PRIMARY: begin
        if (pri_dbl || bak_dbl || (pri_mm && bak_mm)) begin
          fatal_now = 1'b1;
          state_d   = LS_FATAL;
        end else if (pri_mm) begin
          state_d = LS_FAILOVER;
        end
      end
      LS_FAILOVER: state_d = LS_BACKUP;
      LS_BACKUP: begin
        if (bak_dbl || bak_mm) begin
          fatal_now = 1'b1;
          state_d   = LS_FATAL;
        end
      end
      default: state_d = LS_FATAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LS_PRIMARY;
    else     state_q <= state_d;
  end

  assign state   = state_q;
  assign restart = state_q == LS_FAILOVER;
  assign fatal   = state_q == LS_FATAL;

  AST_FAILOVER_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == LS_FAILOVER) |=> (state_q == LS_BACKUP)); // R4
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal); // R8
  AST_BACKUP_NO_RETURN: assert property (@(posedge clk) disable iff (rst)
    (state_q == LS_BACKUP) |=> (state_q != LS_PRIMARY)); // R4
endmodule

// File: rtl/lockstep_spare_ctrl.sv
module lockstep_spare_ctrl
  import lockstep_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CKPT_PERIOD = 8,
  parameter int ADDR_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*DATA_W-1:0] pri_data,
  input  logic [1:0]          pri_vld,
  input  logic [1:0]          pri_err,
  input  logic [2*DATA_W-1:0] bak_data,
  input  logic [1:0]          bak_vld,
  input  logic [1:0]          bak_err,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_vld,
  output logic                pri_stall,
  output logic                bak_stall,
  output logic                restart,
  output logic                ckpt_strobe,
  output logic [ADDR_W-1:0]   ckpt_addr,
  output logic                ckpt_valid,
  output logic                pri_mismatch,
  output logic                bak_mismatch,
  output logic                trust_sel,
  output logic                fatal
);
  localparam int NPAIR = 2;
  localparam int PRI   = 0;
  localparam int BAK   = 1;

  logic [NPAIR-1:0][2*DATA_W-1:0] pr_data;
  logic [NPAIR-1:0][1:0]          pr_vld;
  logic [NPAIR-1:0][1:0]          pr_err;
  logic [NPAIR-1:0]               mm_c, agree_c, dbl_c, trb_c;

  assign pr_data[PRI] = pri_data;
  assign pr_data[BAK] = bak_data;
  assign pr_vld[PRI]  = pri_vld;
  assign pr_vld[BAK]  = bak_vld;
  assign pr_err[PRI]  = pri_err;
  assign pr_err[BAK]  = bak_err;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    ls_pair_cmp #(.DATA_W(DATA_W)) u_cmp (
      .data     (pr_data[g]),
      .vld      (pr_vld[g]),
      .err      (pr_err[g]),
      .mismatch (mm_c[g]),
      .agree    (agree_c[g]),
      .both_err (dbl_c[g]),
      .trust_b  (trb_c[g])
    );
  end

  ls_state_e state;
  logic      fatal_now;

  ls_failover_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pri_mm    (mm_c[PRI]),
    .bak_mm    (mm_c[BAK]),
    .pri_dbl   (dbl_c[PRI]),
    .bak_dbl   (dbl_c[BAK]),
    .state     (state),
    .fatal_now (fatal_now),
    .restart   (restart),
    .fatal     (fatal)
  );

  ls_ckpt_timer #(.CKPT_PERIOD(CKPT_PERIOD), .ADDR_W(ADDR_W)) u_ckpt (
    .clk    (clk),
    .rst    (rst),
    .run    (state == LS_PRIMARY),
    .block  (mm_c[PRI] | fatal_now),
    .strobe (ckpt_strobe),
    .addr   (ckpt_addr),
    .valid  (ckpt_valid)
  );

  logic [DATA_W-1:0] out_data_q;
  logic              out_vld_q;
  logic [NPAIR-1:0]  mm_q;
  logic              trust_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data_q <= '0;
      out_vld_q  <= 1'b0;
      mm_q       <= '0;
      trust_q    <= 1'b0;
    end else begin
      out_vld_q <= 1'b0;
      mm_q      <= mm_c;
      if (!fatal_now) begin
        if (state == LS_PRIMARY && agree_c[PRI]) begin
          out_vld_q  <= 1'b1;
          out_data_q <= pri_data[DATA_W-1:0];
        end else if (state == LS_BACKUP && agree_c[BAK]) begin
          out_vld_q  <= 1'b1;
          out_data_q <= bak_data[DATA_W-1:0];
        end
        if (state == LS_PRIMARY && mm_c[PRI]) trust_q <= trb_c[PRI];
      end
    end
  end

  assign out_data     = out_data_q;
  assign out_vld      = out_vld_q;
  assign pri_mismatch = mm_q[PRI];
  assign bak_mismatch = mm_q[BAK];
  assign trust_sel    = trust_q;
  assign pri_stall    = state != LS_PRIMARY;
  assign bak_stall    = (state == LS_PRIMARY) || (state == LS_FATAL);

  AST_NO_FWD_ON_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |-> !out_vld); // R4
  AST_FATAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    fatal |-> (!out_vld && !restart && pri_stall && bak_stall)); // R8
  AST_MISMATCH_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (pri_mismatch && $past(state == LS_PRIMARY)) |-> !out_vld); // R3
endmodule

// File: tb/lockstep_spare_ctrl_tb.sv
module lockstep_spare_ctrl_tb;
  localparam int DW = 16;
  localparam int PER = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*DW-1:0] pri_data = '0, bak_data = '0;
  logic [1:0] pri_vld = '0, pri_err = '0, bak_vld = '0, bak_err = '0;
  logic [DW-1:0] out_data;
  logic out_vld, pri_stall, bak_stall, restart, ckpt_strobe, ckpt_valid;
  logic pri_mismatch, bak_mismatch, trust_sel, fatal;
  logic [AW-1:0] ckpt_addr;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lockstep_spare_ctrl #(.DATA_W(DW), .CKPT_PERIOD(PER), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst),
    .pri_data(pri_data), .pri_vld(pri_vld), .pri_err(pri_err),
    .bak_data(bak_data), .bak_vld(bak_vld), .bak_err(bak_err),
    .out_data(out_data), .out_vld(out_vld), .pri_stall(pri_stall),
    .bak_stall(bak_stall), .restart(restart), .ckpt_strobe(ckpt_strobe),
    .ckpt_addr(ckpt_addr), .ckpt_valid(ckpt_valid),
    .pri_mismatch(pri_mismatch), .bak_mismatch(bak_mismatch),
    .trust_sel(trust_sel), .fatal(fatal)
  );

  // {pri word 0, pri word 1, pri valids, expected out_vld}
  localparam logic [34:0] VEC [6] = '{
    {16'h1234, 16'h1234, 2'b11, 1'b1},
    {16'h0000, 16'h0000, 2'b11, 1'b1},
    {16'hFFFF, 16'hFFFF, 2'b11, 1'b1},
    {16'h00AA, 16'h0055, 2'b00, 1'b0},
    {16'hA5A5, 16'hA5A5, 2'b11, 1'b1},
    {16'h8001, 16'h8001, 2'b11, 1'b1}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_good(input logic [DW-1:0] p, input logic [DW-1:0] b);
    pri_data = {p, p}; pri_vld = 2'b11; pri_err = 2'b00;
    bak_data = {b, b}; bak_vld = 2'b11; bak_err = 2'b00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pri_data = '0; pri_vld = '0; pri_err = '0;
    bak_data = '0; bak_vld = '0; bak_err = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset();
    check("R1", "out_vld", out_vld, 0);
    check("R1", "restart", restart, 0);
    check("R1", "fatal", fatal, 0);
    check("R1", "ckpt_addr", ckpt_addr, 0);
    check("R1", "ckpt_valid", ckpt_valid, 0);
    check("R1", "stalls", {pri_stall, bak_stall}, 2'b01);
    check("R1", "mismatch", {pri_mismatch, bak_mismatch, trust_sel}, 0);

    // R3: table of agreeing and idle primary patterns
    for (int i = 0; i < 6; i++) begin
      pri_data = VEC[i][34:3]; pri_vld = VEC[i][2:1]; pri_err = 2'b00;
      bak_data = '0; bak_vld = 2'b11; bak_err = 2'b00;
      tick();
      check("R3", "out_vld", out_vld, VEC[i][0]);
      check("R2", "pri_mismatch idle/agree", pri_mismatch, 0);
      if (VEC[i][0]) check("R3", "out_data", out_data, VEC[i][34:19]);
    end

    // R2 R4 R5: data mismatch, element 0 flags itself
    do_reset();
    drive_good(16'h1111, 16'h0BEE);
    tick();
    check("R3", "primary forward", out_data, 16'h1111);
    pri_data = {16'h2222, 16'h2223}; pri_err = 2'b01;
    tick();
    check("R2", "pri_mismatch", pri_mismatch, 1);
    check("R3", "no forward on mismatch", out_vld, 0);
    check("R4", "restart pulse", restart, 1);
    check("R4", "stalls in failover", {pri_stall, bak_stall}, 2'b10);
    check("R5", "trust element 1", trust_sel, 1);
    drive_good(16'h3333, 16'h0BEE);
    tick();
    check("R4", "restart one cycle", restart, 0);
    check("R4", "no forward in failover", out_vld, 0);
    pri_data = {16'h4444, 16'h5555}; pri_err = 2'b11;
    tick();
    check("R4", "backup forwards", {out_vld, out_data}, {1'b1, 16'h0BEE});
    check("R4", "primary ignored", fatal, 0);

    // R2 R5: valid skew with equal data, no self-error flags
    do_reset();
    drive_good(16'h6666, 16'h0);
    pri_vld = 2'b01;
    tick();
    check("R2", "skew mismatch", pri_mismatch, 1);
    check("R4", "skew restart", restart, 1);
    check("R5", "default trust", trust_sel, 0);

    // R6 R7: checkpoint cadence and boundary collision
    do_reset();
    drive_good(16'h0C0C, 16'h0);
    for (int i = 1; i < PER; i++) begin
      tick();
      if (ckpt_strobe) check("R6", "early strobe", ckpt_strobe, 0);
    end
    tick();
    check("R6", "first strobe", {ckpt_strobe, ckpt_valid, ckpt_addr}, {2'b11, 4'd1});
    tick();
    check("R6", "strobe one cycle", ckpt_strobe, 0);
    for (int i = 2; i < PER; i++) tick();
    tick();
    check("R6", "second strobe", {ckpt_strobe, ckpt_addr}, {1'b1, 4'd2});
    for (int i = 1; i < PER; i++) tick();
    pri_data = {16'h0C0C, 16'h0C0D};
    tick();
    check("R7", "no strobe at fault boundary", ckpt_strobe, 0);
    check("R7", "slot kept", ckpt_addr, 2);
    check("R7", "failover taken", restart, 1);
    drive_good(16'h0C0C, 16'h0);
    for (int i = 0; i < 2 * PER; i++) tick();
    check("R7", "counter halted", {ckpt_strobe, ckpt_addr}, {1'b0, 4'd2});

    // R8: both pairs disagree
    do_reset();
    drive_good(16'h1, 16'h2);
    pri_data = {16'h1, 16'h9}; bak_data = {16'h2, 16'h8};
    tick();
    check("R8", "fatal set", fatal, 1);
    check("R8", "quiet", {out_vld, restart, pri_stall, bak_stall}, 4'b0011);
    drive_good(16'h1, 16'h2);
    tick(); tick(); tick();
    check("R8", "fatal sticky", {fatal, out_vld}, 2'b10);
    do_reset();
    check("R8", "reset clears fatal", fatal, 0);
    drive_good(16'h1, 16'h2);
    bak_err = 2'b11;
    tick();
    check("R8", "double self-error", fatal, 1);

    // R9: backup fails after takeover
    do_reset();
    drive_good(16'h1, 16'h2);
    pri_vld = 2'b10;
    tick();
    drive_good(16'h1, 16'h2);
    tick(); tick();
    check("R9", "backup running", {out_vld, fatal}, 2'b10);
    bak_data = {16'h2, 16'h3};
    tick();
    check("R9", "backup mismatch fatal", fatal, 1);

    // R10: stray backup disagreement during primary operation
    do_reset();
    drive_good(16'h7777, 16'h0);
    bak_data = {16'h1, 16'h2};
    tick();
    check("R10", "bak flag", bak_mismatch, 1);
    check("R10", "still primary", {out_vld, out_data, restart, fatal},
          {1'b1, 16'h7777, 2'b00});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule